// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable model of a single-port synchronous SRAM. It has a flow-through read path, and no idle cycle is needed when it switches between reads and writes. A rising clock edge with the clock enable active is decoded into one operation, chosen from the chip selects, the load/advance strobe and the write controls:

- deselect or continue deselect
- begin a read or write burst at an external address
- continue the running burst at the next internal address

A read burst started while output enable is inactive is a dummy read. A write beat with no lane select active is a write abort. Both still move the burst address. A high clock enable gates the edge off, which is a stall. A sleep input freezes the block and floats the bus.

Read data comes from the array at the registered address in the cycle after that address is taken in. Write data is taken one enabled edge after its address, so reads and writes can interleave on every cycle. The tristate data bus is split into an input, an output and an output-drive flag. The drive flag responds to output enable without waiting for a clock.

Top module: `sync_burst_sram`

## Requirements
- R1: With `adv_ld`=0 on an enabled edge, `ce1_n`=1, `ce3_n`=1 or `ce2`=0 deselects the block, and `dout_en` is 0 in the following cycle.
- R2: With `adv_ld`=1 on an enabled edge while deselected, the block stays deselected and `dout_en` stays 0.
- R3: With `adv_ld`=0, all selects active and `we_n`=1, a read burst starts at `addr`. In the next cycle `dout` equals the word at that address, and `dout_en`=1 when `oe_n`=0.
- R4: A read burst started while `oe_n`=1 keeps `dout_en` at 0, but the burst address still loads, so a following beat reads the next address.
- R5: With `adv_ld`=0, all selects active, `we_n`=0 and at least one `bw_n` bit at 0, a write burst starts. `bw_n[i]`=0 enables lane i, which is `din[9*i+8:9*i]`. `din` is taken at the next enabled edge, and only the enabled lanes of the word are changed.
- R6: A write beat with `bw_n` all ones leaves the array unchanged but loads or advances the burst address like any write.
- R7: Each continue beat adds one to the two low address bits and wraps from 3 to 0. The upper address bits stay fixed for the whole burst.
- R8: With `adv_ld`=1 on an enabled edge, an active burst keeps the read or write type that was loaded at its start.
- R9: When `cen_n`=1, the edge changes nothing: burst address, operation type, any pending write and `dout` all hold.
- R10: While `sleep`=1, all other inputs are ignored, state holds and `dout_en` is 0.
- R11: `dout_en` follows `oe_n` combinationally during a read. It is forced to 0 while the current operation is a write.
- R12: During and after reset the block is deselected and `dout_en` is 0, whatever the level of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads an external address, 1 continues the current operation |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | 4 | Lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| cen_n | input | 1 | Clock enable, active low |
| sleep | input | 1 | Low-power freeze, active high |
| addr | input | 6 | External word address |
| din | input | 36 | Write data, four 9-bit lanes |
| dout | output | 36 | Read data |
| dout_en | output | 1 | Data bus drive flag |

## Verification
Two functions can fall in the same edge. One is the delayed data capture of a write beat. The other is the decode of a new operation, which may be a read of the word being written or a stall that must postpone the capture. The bench provokes both cases:

- a write burst followed directly by a read burst at the same address
- a clock-enable stall placed between a write address and its data

In both cases the reference model decides whether the read shows the merged lanes, and at which edge the lanes really change. Random traffic with a mix of stalls, aborts and partial lane selects then exercises the same overlap many more times.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_DESEL,
    OP_IDLE_ON,
    OP_LOAD_RD,
    OP_LOAD_WR,
    OP_NEXT
  } sbs_op_e;

endpackage

// File: rtl/sbs_op_decode.sv
module sbs_op_decode
  import sbs_pkg::*;
(
  input  logic    cen_n,
  input  logic    sleep,
  input  logic    ce1_n,
  input  logic    ce2,
  input  logic    ce3_n,
  input  logic    adv_ld,
  input  logic    we_n,
  input  logic    busy_q,
  output sbs_op_e op
);

  logic edge_on;
  logic picked;

  assign edge_on = !cen_n && !sleep;
  assign picked  = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    op = OP_HOLD;
    if (edge_on) begin
      if (!adv_ld) begin
        if (!picked)    op = OP_DESEL;
        else if (we_n)  op = OP_LOAD_RD;
        else            op = OP_LOAD_WR;
      end else begin
        op = busy_q ? OP_NEXT : OP_IDLE_ON;
      end
    end
  end

endmodule

// File: rtl/sbs_burst_step.sv
module sbs_burst_step #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);

  logic [BURST_W-1:0] low_inc;

  assign low_inc  = cur_addr[BURST_W-1:0] + 1'b1;
  assign nxt_addr = {cur_addr[ADDR_W-1:BURST_W], low_inc};

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_go,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_go && wr_lanes[g]) begin
        cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adv_ld,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    cen_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int WORD_W = LANES * LANE_W;

  sbs_op_e           op;
  logic              busy_q, busy_d;
  logic              isw_q, isw_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, ptr_step;
  logic              pend_q, pend_d;
  logic [LANES-1:0]  plane_q, plane_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              commit;

  sbs_op_decode u_dec (
    .cen_n  (cen_n),
    .sleep  (sleep),
    .ce1_n  (ce1_n),
    .ce2    (ce2),
    .ce3_n  (ce3_n),
    .adv_ld (adv_ld),
    .we_n   (we_n),
    .busy_q (busy_q),
    .op     (op)
  );

  sbs_burst_step #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_step (
    .cur_addr (ptr_q),
    .nxt_addr (ptr_step)
  );

  assign commit = (op != OP_HOLD) && pend_q;

  sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk      (clk),
    .wr_go    (commit),
    .wr_lanes (plane_q),
    .wr_addr  (paddr_q),
    .wr_data  (din),
    .rd_addr  (ptr_q),
    .rd_data  (dout)
  );

  always_comb begin
    busy_d  = busy_q;
    isw_d   = isw_q;
    ptr_d   = ptr_q;
    pend_d  = pend_q;
    plane_d = plane_q;
    paddr_d = paddr_q;
    unique case (op)
      OP_DESEL:   busy_d = 1'b0;
      OP_LOAD_RD: begin busy_d = 1'b1; isw_d = 1'b0; ptr_d = addr; end
      OP_LOAD_WR: begin busy_d = 1'b1; isw_d = 1'b1; ptr_d = addr; end
      OP_NEXT:    ptr_d = ptr_step;
      default:    ;
    endcase
    if (op != OP_HOLD) begin
      pend_d  = busy_d && isw_d;
      plane_d = ~bw_n;
      paddr_d = ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      isw_q   <= 1'b0;
      ptr_q   <= '0;
      pend_q  <= 1'b0;
      plane_q <= '0;
      paddr_q <= '0;
    end else begin
      busy_q  <= busy_d;
      isw_q   <= isw_d;
      ptr_q   <= ptr_d;
      pend_q  <= pend_d;
      plane_q <= plane_d;
      paddr_q <= paddr_d;
    end
  end

  assign dout_en = rst_n && busy_q && !isw_q && !oe_n && !sleep;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ce1_n,
  input logic                    ce2,
  input logic                    ce3_n,
  input logic                    adv_ld,
  input logic                    we_n,
  input logic                    oe_n,
  input logic                    cen_n,
  input logic                    sleep,
  input logic [LANES*LANE_W-1:0] dout,
  input logic                    dout_en
);

  logic pick, live;
  assign pick = !ce1_n && ce2 && !ce3_n;
  assign live = !cen_n && !sleep;

  AST_DESEL_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !adv_ld && !pick) |=> !dout_en); // R1

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !adv_ld && pick && we_n) |=> (dout_en || oe_n || sleep)); // R3

  AST_WRITE_MASKS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !adv_ld && pick && !we_n) |=> !dout_en); // R11

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en); // R11

  AST_SLEEP_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en); // R10

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && !sleep) |=> $stable(dout)); // R9

  always_comb begin
    if (!rst_n) begin
      AST_RESET_FLOATS: assert (!dout_en); // R12
    end
  end

endmodule

bind sync_burst_sram sbs_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_sbs_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce1_n   (ce1_n),
  .ce2     (ce2),
  .ce3_n   (ce3_n),
  .adv_ld  (adv_ld),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .cen_n   (cen_n),
  .sleep   (sleep),
  .dout    (dout),
  .dout_en (dout_en)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce1_n, ce2, ce3_n, adv_ld, we_n, oe_n, cen_n, sleep;
  logic [NL-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [WW-1:0] din;
  logic [WW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R12";

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .cen_n(cen_n),
    .sleep(sleep), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // reference model
  logic [WW-1:0] m_mem [DEPTH];
  bit            m_known [DEPTH];
  bit            m_act, m_wr, m_pend;
  int            m_addr, m_paddr;
  logic [NL-1:0] m_lanes;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_pend = 0; m_addr = 0;
    end else if (!cen_n && !sleep) begin
      if (m_pend) begin
        for (int l = 0; l < NL; l++)
          if (m_lanes[l]) m_mem[m_paddr][l*LW +: LW] = din[l*LW +: LW];
        if (m_lanes == '1) m_known[m_paddr] = 1;
      end
      if (!adv_ld) begin
        if (!ce1_n && ce2 && !ce3_n) begin
          m_act = 1; m_wr = !we_n; m_addr = addr;
        end else m_act = 0;
      end else if (m_act) begin
        m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
      end
      m_pend  = m_act && m_wr;
      m_paddr = m_addr;
      m_lanes = ~bw_n;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit exp_en;
    exp_en = m_act && !m_wr && !oe_n && !sleep && rst_n;
    chk(dout_en == exp_en, cur_req, "dout_en", WW'(dout_en), WW'(exp_en));
    if (exp_en && m_known[m_addr])
      chk(dout == m_mem[m_addr], cur_req, "dout", dout, m_mem[m_addr]);
  endtask

  // one clock: inputs already set, new din drawn, compare after edge
  task automatic step();
    din = {$urandom, $urandom};
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle_in();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adv_ld = 1; we_n = 1; bw_n = '1;
    cen_n = 0; sleep = 0;
  endtask

  task automatic load(int a, bit wr, logic [NL-1:0] bw, bit oe);
    idle_in(); adv_ld = 0; we_n = !wr; bw_n = bw; oe_n = oe; addr = AW'(a);
    step();
  endtask

  task automatic cont(logic [NL-1:0] bw, bit oe);
    idle_in(); adv_ld = 1; bw_n = bw; oe_n = oe; addr = $urandom;
    step();
  endtask

  task automatic desel(int which);
    idle_in(); adv_ld = 0;
    case (which)
      0: ce1_n = 1;
      1: ce3_n = 1;
      default: ce2 = 0;
    endcase
    step();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
    idle_in(); oe_n = 0; addr = 0; din = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    cur_req = "R12";
    chk(dout_en == 0, "R12", "reset float", WW'(dout_en), 0);
    rst_n = 1;
    step(); // continue beat while deselected after reset
    chk(dout_en == 0, "R12", "after reset", WW'(dout_en), 0);

    // fill array with full-lane write bursts
    cur_req = "R5";
    for (int b = 0; b < DEPTH/4; b++) begin
      load(b*4, 1, '0, 0);
      for (int k = 0; k < 3; k++) cont('0, 0);
    end
    desel(0);

    // read burst with wrap from 5
    cur_req = "R7";
    load(5, 0, '1, 0);
    for (int k = 0; k < 5; k++) cont('1, 0);
    cur_req = "R3";
    load(40, 0, '1, 0);

    // dummy read then reveal
    cur_req = "R4";
    load(18, 0, '1, 1);
    chk(dout_en == 0, "R4", "dummy float", WW'(dout_en), 0);
    cont('1, 0);

    // partial lanes and abort mid burst
    cur_req = "R5";
    load(8, 1, 4'b1010, 0);
    cont(4'b0110, 0);
    cur_req = "R6";
    cont(4'b1111, 0);
    cont(4'b1110, 0);
    cur_req = "R8";
    load(8, 0, '1, 0);
    for (int k = 0; k < 4; k++) cont('1, 0);

    // write directly followed by read of same word
    cur_req = "R5";
    load(30, 1, 4'b0011, 0);
    load(30, 0, '1, 0);

    // stall between write address and its data, and during a read
    cur_req = "R9";
    load(33, 1, '0, 0);
    idle_in(); cen_n = 1; adv_ld = 0; we_n = 1; addr = 0; step();
    idle_in(); cen_n = 1; step();
    load(33, 0, '1, 0);
    idle_in(); cen_n = 1; adv_ld = 0; addr = 1; step();
    cont('1, 0);

    // deselect variants and continue deselect
    for (int w = 0; w < 3; w++) begin
      cur_req = "R3";
      load(12 + w, 0, '1, 0);
      cur_req = "R1";
      desel(w);
      cur_req = "R2";
      cont('1, 0);
      chk(dout_en == 0, "R2", "stay deselected", WW'(dout_en), 0);
    end

    // sleep during read burst
    cur_req = "R10";
    load(50, 0, '1, 0);
    idle_in(); sleep = 1; adv_ld = 0; we_n = 0; bw_n = '0; addr = 3; step();
    chk(dout_en == 0, "R10", "sleep float", WW'(dout_en), 0);
    cont('1, 0);

    // asynchronous output enable
    cur_req = "R11";
    load(20, 0, '1, 0);
    oe_n = 1; #1;
    chk(dout_en == 0, "R11", "oe off async", WW'(dout_en), 0);
    oe_n = 0; #1;
    chk(dout_en == 1, "R11", "oe on async", WW'(dout_en), 1);
    load(21, 1, '1, 0);
    #1;
    chk(dout_en == 0, "R11", "write masks oe", WW'(dout_en), 0);

    // random traffic
    cur_req = "R8";
    for (int n = 0; n < 2000; n++) begin
      ce1_n  = ($urandom % 8) == 0;
      ce2    = ($urandom % 8) != 0;
      ce3_n  = ($urandom % 8) == 0;
      adv_ld = $urandom % 2;
      we_n   = $urandom % 2;
      bw_n   = $urandom;
      oe_n   = ($urandom % 5) == 0;
      cen_n  = ($urandom % 6) == 0;
      sleep  = ($urandom % 12) == 0;
      addr   = $urandom;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule